// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end of a parallel NOR flash device, with a small array held in registers. A host drives a chip-select style bus: chip select, write strobe and read strobe, all active low, plus a word address and a byte of data. Every write while the device is selected goes to the command decoder, because the command register has no address of its own. The decoder picks what a read returns: array data, the status register, identifier codes or a fixed query table. It also starts the modifying operations: block erase, word program, lock one block, and unlock all blocks.

Modifying operations run for a latency that the host sets, in clock cycles. During that time the device reports busy and reads return status. A program-enable input must be high for any change to the array or to the lock bits. A separate device reset input aborts a running operation, drops a half-entered command and puts the device back in array-read mode, so a host that leaves reset reads data and not status.

Command codes: 0xFF read array, 0x70 read status, 0x50 clear status, 0x90 identifier, 0x98 query, 0x20+0xD0 erase, 0x40+data program, 0x60+0x01 lock block, 0x60+0xD0 unlock all. Status bits: 7 ready, 5 erase error, 4 program error, 3 program-enable-low error, 1 locked-block error. All other status bits read as zero.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: A write takes effect at its end, which is the first of the write strobe or the chip select going high. It uses the address and data presented while both were low. The new read mode is visible on the cycle after that end.
- R2: 0xFF selects array reads, 0x70 status reads, 0x90 identifier reads and 0x98 query reads. Any other single code leaves the read mode unchanged.
- R3: In identifier mode, word offset 0 within a block reads the manufacturer code (0xC3) and offset 1 reads the device code (0x17). Offset 2 reads the lock bit of the addressed block in bit 0. All other offsets read 0.
- R4: In query mode, the offset within a block indexes a table. Offsets 0..2 read 0x51, 0x52 and 0x59, and offsets 3..6 read the address width, the block-offset width, the block count and the latency-port width. All other offsets read 0.
- R5: 0x40 followed by data programs the addressed word to old AND data. The read mode then becomes status.
- R6: 0x20 followed by 0xD0 sets every word of the addressed block to 0xFF and leaves other blocks unchanged. Any other second byte counts as a bad confirm (R10).
- R7: 0x60+0x01 locks the addressed block and 0x60+0xD0 unlocks all blocks. An erase or program aimed at a locked block leaves the array unchanged and sets bit 1 together with bit 5 (erase) or bit 4 (program). Lock bits change only when an operation ends.
- R8: With program-enable low, the array and lock bits are unchanged. The attempt sets bit 3 together with bit 5 (erase, unlock) or bit 4 (program, lock).
- R9: An operation holds ready (port and status bit 7) low for max(lat,1) cycles. While busy, reads return status and writes are ignored.
- R10: A wrong second byte after 0x20 or 0x60 sets status bits 5 and 4 at once, starts nothing and selects status mode.
- R11: Error bits stay set until 0x50 clears them. 0x50 leaves the read mode unchanged.
- R12: Device reset low aborts a running operation and forces array-read mode. It discards the first byte of a two-byte command. Locks and unmodified data are kept.
- R13: The data output reads 0 unless chip select and read strobe are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset, released synchronously |
| dev_rst_n | input | 1 | Device reset, active low, sampled on the clock |
| prog_en | input | 1 | High allows erase, program and lock changes |
| lat | input | LAT_W | Operation latency in cycles (0 behaves as 1) |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Read strobe, active low |
| addr | input | ADDR_W | Word address |
| din | input | 8 | Write data and command byte |
| dout | output | 8 | Read data |
| ready | output | 1 | High when no operation is running |

## Verification
The bench keeps the default configuration: a 6-bit address with 4-bit block offsets, which gives 4 blocks of 16 words, and a 5-bit latency port. This makes the full array small enough to program and read back word by word. It also lets the bench walk every identifier and query offset and lock and erase each block boundary. The latency sweeps 0 through 5 during programming, and runs of 20 cycles leave room to inject writes and device resets in the middle of an operation.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int DATA_W = 8;
  localparam int ERR_W  = 7;

  typedef enum logic [1:0] {RM_ARRAY, RM_STATUS, RM_ID, RM_QUERY} rd_mode_e;
  typedef enum logic [1:0] {PD_NONE, PD_ERASE, PD_PROG, PD_LOCK} pend_e;
  typedef enum logic [1:0] {OP_ERASE, OP_PROG, OP_LSET, OP_LCLR} op_e;

  localparam logic [DATA_W-1:0] C_RD_ARRAY = 8'hFF;
  localparam logic [DATA_W-1:0] C_RD_STAT  = 8'h70;
  localparam logic [DATA_W-1:0] C_CLR_STAT = 8'h50;
  localparam logic [DATA_W-1:0] C_RD_ID    = 8'h90;
  localparam logic [DATA_W-1:0] C_RD_QRY   = 8'h98;
  localparam logic [DATA_W-1:0] C_ERASE    = 8'h20;
  localparam logic [DATA_W-1:0] C_PROG     = 8'h40;
  localparam logic [DATA_W-1:0] C_LOCK     = 8'h60;
  localparam logic [DATA_W-1:0] C_CONFIRM  = 8'hD0;
  localparam logic [DATA_W-1:0] C_LSET     = 8'h01;

  localparam int SB_READY = 7;
  localparam int SB_ERASE = 5;
  localparam int SB_PROG  = 4;
  localparam int SB_PEN   = 3;
  localparam int SB_LOCK  = 1;
endpackage

// File: rtl/fcc_bus_capture.sv
module fcc_bus_capture #(
  parameter int ADDR_W = 6
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ce_n,
  input  logic                      we_n,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [fcc_pkg::DATA_W-1:0] din,
  output logic                      cmd_vld,
  output logic [ADDR_W-1:0]         cmd_addr,
  output logic [fcc_pkg::DATA_W-1:0] cmd_data
);
  logic                       wr_act;
  logic                       act_q;
  logic [ADDR_W-1:0]          addr_q;
  logic [fcc_pkg::DATA_W-1:0] data_q;

  assign wr_act = !ce_n && !we_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      act_q <= wr_act;
      if (wr_act) begin
        addr_q <= addr;
        data_q <= din;
      end
    end
  end

  // whichever strobe rises first ends the write
  assign cmd_vld  = act_q && !wr_act;
  assign cmd_addr = addr_q;
  assign cmd_data = data_q;
endmodule

// File: rtl/fcc_cmd_decode.sv
module fcc_cmd_decode
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst_n,
  input  logic              cmd_vld,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_data,
  input  logic              busy,
  output rd_mode_e          mode,
  output logic              op_start,
  output op_e               op_kind,
  output logic [ADDR_W-1:0] op_addr,
  output logic [DATA_W-1:0] op_data,
  output logic              seq_err,
  output logic              clr_err
);
  rd_mode_e mode_q, mode_d;
  pend_e    pend_q, pend_d;

  always_comb begin
    mode_d   = mode_q;
    pend_d   = pend_q;
    op_start = 1'b0;
    op_kind  = OP_PROG;
    seq_err  = 1'b0;
    clr_err  = 1'b0;
    if (!dev_rst_n) begin
      mode_d = RM_ARRAY;
      pend_d = PD_NONE;
    end else if (cmd_vld && !busy) begin
      unique case (pend_q)
        PD_NONE: begin
          unique case (cmd_data)
            C_RD_ARRAY: mode_d = RM_ARRAY;
            C_RD_STAT:  mode_d = RM_STATUS;
            C_RD_ID:    mode_d = RM_ID;
            C_RD_QRY:   mode_d = RM_QUERY;
            C_CLR_STAT: clr_err = 1'b1;
            C_ERASE: begin pend_d = PD_ERASE; mode_d = RM_STATUS; end
            C_PROG:  begin pend_d = PD_PROG;  mode_d = RM_STATUS; end
            C_LOCK:  begin pend_d = PD_LOCK;  mode_d = RM_STATUS; end
            default: ;
          endcase
        end
        PD_ERASE: begin
          pend_d = PD_NONE;
          mode_d = RM_STATUS;
          if (cmd_data == C_CONFIRM) begin
            op_start = 1'b1;
            op_kind  = OP_ERASE;
          end else begin
            seq_err = 1'b1;
          end
        end
        PD_PROG: begin
          pend_d   = PD_NONE;
          mode_d   = RM_STATUS;
          op_start = 1'b1;
          op_kind  = OP_PROG;
        end
        PD_LOCK: begin
          pend_d = PD_NONE;
          mode_d = RM_STATUS;
          if (cmd_data == C_LSET) begin
            op_start = 1'b1;
            op_kind  = OP_LSET;
          end else if (cmd_data == C_CONFIRM) begin
            op_start = 1'b1;
            op_kind  = OP_LCLR;
          end else begin
            seq_err = 1'b1;
          end
        end
        default: pend_d = PD_NONE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_ARRAY;
      pend_q <= PD_NONE;
    end else begin
      mode_q <= mode_d;
      pend_q <= pend_d;
    end
  end

  assign mode    = mode_q;
  assign op_addr = cmd_addr;
  assign op_data = cmd_data;
endmodule

// File: rtl/fcc_op_engine.sv
module fcc_op_engine
  import fcc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int BLK_W  = 4,
  parameter int LAT_W  = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              dev_rst_n,
  input  logic                              prog_en,
  input  logic [LAT_W-1:0]                  lat,
  input  logic                              start,
  input  op_e                               kind,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 data,
  input  logic                              seq_err,
  input  logic                              clr_err,
  input  logic [ADDR_W-1:0]                 rd_addr,
  output logic                              busy,
  output logic [DATA_W-1:0]                 status,
  output logic [(1 << (ADDR_W-BLK_W))-1:0]  locks,
  output logic [DATA_W-1:0]                 rd_word
);
  localparam int BSEL_W    = ADDR_W - BLK_W;
  localparam int NUM_BLK   = 1 << BSEL_W;
  localparam int NUM_WORDS = 1 << ADDR_W;

  logic                busy_q, busy_d;
  logic [LAT_W-1:0]    cnt_q, cnt_d;
  op_e                 kind_q, kind_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   data_q, data_d;
  logic [ERR_W-1:0]    fail_q, fail_d, fail_new;
  logic [ERR_W-1:0]    err_q, err_d;
  logic [NUM_BLK-1:0]  lock_q, lock_d;
  logic [DATA_W-1:0]   mem_q [NUM_WORDS];
  logic [NUM_WORDS-1:0] word_we;
  logic                done, apply;
  logic [BSEL_W-1:0]   new_blk;

  assign new_blk = addr[ADDR_W-1:BLK_W];
  assign done    = busy_q && dev_rst_n && (cnt_q == LAT_W'(1));
  assign apply   = done && (fail_q == '0);

  // failure is fixed when the operation is accepted
  always_comb begin
    fail_new = '0;
    unique case (kind)
      OP_ERASE: begin
        fail_new[SB_ERASE] = !prog_en || lock_q[new_blk];
        fail_new[SB_PEN]   = !prog_en;
        fail_new[SB_LOCK]  = prog_en && lock_q[new_blk];
      end
      OP_PROG: begin
        fail_new[SB_PROG]  = !prog_en || lock_q[new_blk];
        fail_new[SB_PEN]   = !prog_en;
        fail_new[SB_LOCK]  = prog_en && lock_q[new_blk];
      end
      OP_LSET: begin
        fail_new[SB_PROG]  = !prog_en;
        fail_new[SB_PEN]   = !prog_en;
      end
      OP_LCLR: begin
        fail_new[SB_ERASE] = !prog_en;
        fail_new[SB_PEN]   = !prog_en;
      end
      default: ;
    endcase
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    kind_d = kind_q;
    addr_d = addr_q;
    data_d = data_q;
    fail_d = fail_q;
    err_d  = err_q;
    lock_d = lock_q;
    if (!dev_rst_n) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (start) begin
      busy_d = 1'b1;
      cnt_d  = (lat == '0) ? LAT_W'(1) : lat;
      kind_d = kind;
      addr_d = addr;
      data_d = data;
      fail_d = fail_new;
    end else if (busy_q) begin
      cnt_d = cnt_q - LAT_W'(1);
      if (cnt_q == LAT_W'(1)) busy_d = 1'b0;
    end
    if (clr_err) err_d = '0;
    if (seq_err) begin
      err_d[SB_ERASE] = 1'b1;
      err_d[SB_PROG]  = 1'b1;
    end
    if (done) err_d = err_q | fail_q;
    if (apply && kind_q == OP_LSET) lock_d[addr_q[ADDR_W-1:BLK_W]] = 1'b1;
    if (apply && kind_q == OP_LCLR) lock_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      kind_q <= OP_PROG;
      addr_q <= '0;
      data_q <= '0;
      fail_q <= '0;
      err_q  <= '0;
      lock_q <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      addr_q <= addr_d;
      data_q <= data_d;
      fail_q <= fail_d;
      err_q  <= err_d;
      lock_q <= lock_d;
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    localparam logic [ADDR_W-1:0] WA = ADDR_W'(g);
    assign word_we[g] = apply &&
      ((kind_q == OP_ERASE && WA[ADDR_W-1:BLK_W] == addr_q[ADDR_W-1:BLK_W]) ||
       (kind_q == OP_PROG  && WA == addr_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < NUM_WORDS; w++) mem_q[w] <= '1;
    end else begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (word_we[w]) mem_q[w] <= (kind_q == OP_ERASE) ? '1 : (mem_q[w] & data_q);
      end
    end
  end

  assign busy    = busy_q;
  assign status  = {~busy_q, err_q};
  assign locks   = lock_q;
  assign rd_word = mem_q[rd_addr];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcc_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          BLK_W    = 4,
  parameter int          LAT_W    = 5,
  parameter logic [7:0]  MFR_CODE = 8'hC3,
  parameter logic [7:0]  DEV_CODE = 8'h17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_rst_n,
  input  logic              prog_en,
  input  logic [LAT_W-1:0]  lat,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              ready
);
  localparam int NUM_BLK = 1 << (ADDR_W - BLK_W);

  logic [1:0]          rs_q;
  logic                rst_i;
  logic                cmd_vld;
  logic [ADDR_W-1:0]   cmd_addr, op_addr;
  logic [DATA_W-1:0]   cmd_data, op_data;
  rd_mode_e            mode_w;
  logic                op_start, seq_err, clr_err, busy;
  op_e                 op_kind;
  logic [DATA_W-1:0]   status_w, rd_word, rdata;
  logic [NUM_BLK-1:0]  locks_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  fcc_bus_capture #(.ADDR_W(ADDR_W)) u_cap (
    .clk(clk), .rst_n(rst_i), .ce_n(ce_n), .we_n(we_n), .addr(addr), .din(din),
    .cmd_vld(cmd_vld), .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fcc_cmd_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_i), .dev_rst_n(dev_rst_n), .cmd_vld(cmd_vld),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .busy(busy), .mode(mode_w),
    .op_start(op_start), .op_kind(op_kind), .op_addr(op_addr), .op_data(op_data),
    .seq_err(seq_err), .clr_err(clr_err)
  );

  fcc_op_engine #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .LAT_W(LAT_W)) u_eng (
    .clk(clk), .rst_n(rst_i), .dev_rst_n(dev_rst_n), .prog_en(prog_en), .lat(lat),
    .start(op_start), .kind(op_kind), .addr(op_addr), .data(op_data),
    .seq_err(seq_err), .clr_err(clr_err), .rd_addr(addr), .busy(busy),
    .status(status_w), .locks(locks_w), .rd_word(rd_word)
  );

  always_comb begin
    rdata = '0;
    if (busy) begin
      rdata = status_w;
    end else begin
      unique case (mode_w)
        RM_ARRAY:  rdata = rd_word;
        RM_STATUS: rdata = status_w;
        RM_ID: begin
          unique case (addr[BLK_W-1:0])
            BLK_W'(0): rdata = MFR_CODE;
            BLK_W'(1): rdata = DEV_CODE;
            BLK_W'(2): rdata = {7'b0, locks_w[addr[ADDR_W-1:BLK_W]]};
            default:   rdata = '0;
          endcase
        end
        RM_QUERY: begin
          unique case (addr[BLK_W-1:0])
            BLK_W'(0): rdata = 8'h51;
            BLK_W'(1): rdata = 8'h52;
            BLK_W'(2): rdata = 8'h59;
            BLK_W'(3): rdata = 8'(ADDR_W);
            BLK_W'(4): rdata = 8'(BLK_W);
            BLK_W'(5): rdata = 8'(NUM_BLK);
            BLK_W'(6): rdata = 8'(LAT_W);
            default:   rdata = '0;
          endcase
        end
        default: rdata = '0;
      endcase
    end
  end

  assign dout  = (!ce_n && !oe_n) ? rdata : '0;
  assign ready = !busy;
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import fcc_pkg::*;
#(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          dev_rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic [7:0]    dout,
  input logic          ready,
  input logic          op_start,
  input logic          seq_err,
  input logic          clr_err,
  input logic [7:0]    status,
  input logic [NB-1:0] locks,
  input rd_mode_e      mode
);
  a_r9_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> !ready);

  a_r9_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && !ce_n && !oe_n) |-> !dout[7]);

  a_r7_locks_move_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && $past(ready)) |-> $stable(locks));

  a_r10_bad_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> (status[5] && status[4]));

  a_r11_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (status[5:1] == 5'b0));

  a_r12_dev_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_rst_n |=> (mode == RM_ARRAY && ready));
endmodule

bind flash_cmd_ctrl fcc_checker #(.NB(1 << (ADDR_W - BLK_W))) u_chk (
  .clk(clk), .rst_n(rst_i), .dev_rst_n(dev_rst_n), .ce_n(ce_n), .oe_n(oe_n),
  .dout(dout), .ready(ready), .op_start(op_start), .seq_err(seq_err),
  .clr_err(clr_err), .status(status_w), .locks(locks_w), .mode(mode_w)
);

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  localparam int ADDR_W = 6;
  localparam int BLK_W  = 4;
  localparam int LAT_W  = 5;
  localparam int NW     = 1 << ADDR_W;
  localparam int NB     = 1 << (ADDR_W - BLK_W);

  logic              clk = 1'b0;
  logic              rst_n, dev_rst_n, prog_en, ce_n, we_n, oe_n;
  logic [LAT_W-1:0]  lat;
  logic [ADDR_W-1:0] addr;
  logic [7:0]        din, dout;
  logic              ready;

  int checks = 0;
  int errors = 0;
  logic [7:0] model [NW];
  logic [NB-1:0] lmodel;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .LAT_W(LAT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_rst_n(dev_rst_n), .prog_en(prog_en), .lat(lat),
    .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din),
    .dout(dout), .ready(ready)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d, input bit by_ce);
    @(negedge clk);
    addr = ADDR_W'(a); din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    @(negedge clk);
    if (by_ce) ce_n = 1'b1; else we_n = 1'b1;
    @(negedge clk);
    ce_n = 1'b1; we_n = 1'b1;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk);
    addr = ADDR_W'(a); ce_n = 1'b0; oe_n = 1'b0;
    #1;
    d = dout;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic rd_chk(input int a, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    rd(a, d);
    chk(tag, d, exp);
  endtask

  task automatic op2(input int a, input logic [7:0] c1, input logic [7:0] c2);
    int n;
    wr(a, c1, 1'b0);
    wr(a, c2, 1'b1);
    wait_ready(n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] d, p;
    rst_n = 1'b0; dev_rst_n = 1'b1; prog_en = 1'b1; ce_n = 1'b1; we_n = 1'b1;
    oe_n = 1'b1; addr = '0; din = '0; lat = LAT_W'(3);
    for (int i = 0; i < NW; i++) model[i] = 8'hFF;
    lmodel = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    chk("R9 ready after reset", {7'b0, ready}, 8'h01);
    rd_chk(0, 8'hFF, "R2 reset reads erased array");
    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; #1;
    chk("R13 oe high gives zero", dout, 8'h00);
    ce_n = 1'b1; oe_n = 1'b0; #1;
    chk("R13 ce high gives zero", dout, 8'h00);
    oe_n = 1'b1;

    // identifier sweep
    wr(0, 8'h90, 1'b0);
    for (int b = 0; b < NB; b++) begin
      rd_chk(b*16 + 0, 8'hC3, "R3 manufacturer code");
      rd_chk(b*16 + 1, 8'h17, "R3 device code");
      rd_chk(b*16 + 2, 8'h00, "R3 unlocked block");
      rd_chk(b*16 + 3, 8'h00, "R3 reserved offset");
    end
    // query sweep
    wr(0, 8'h98, 1'b1);
    for (int i = 0; i < 16; i++) begin
      case (i)
        0: p = 8'h51; 1: p = 8'h52; 2: p = 8'h59;
        3: p = 8'(ADDR_W); 4: p = 8'(BLK_W); 5: p = 8'(NB); 6: p = 8'(LAT_W);
        default: p = 8'h00;
      endcase
      rd_chk(16 + i, p, "R4 query table");
    end
    wr(0, 8'h70, 1'b0);
    rd_chk(0, 8'h80, "R2 status mode");
    wr(0, 8'h33, 1'b0);
    rd_chk(0, 8'h80, "R2 unknown code keeps mode");
    wr(0, 8'hFF, 1'b1);
    rd_chk(0, 8'hFF, "R2 back to array");

    // program sweep, latency 0..5, both write-end styles
    for (int a = 0; a < NW; a++) begin
      lat = LAT_W'(a % 6);
      p = 8'((a * 37 + 5) & 8'hFF);
      wr(a, 8'h40, (a % 2) == 1);
      wr(a, p, (a % 2) == 0);
      model[a] = model[a] & p;
      wait_ready(n);
      chk("R9 latency cycles", 8'(n), 8'((a % 6 == 0) ? 1 : a % 6));
      if (a < 4) rd_chk(a, 8'h80, "R5 status after program");
    end
    wr(0, 8'hFF, 1'b0);
    for (int a = 0; a < NW; a++) rd_chk(a, model[a], "R5 R1 programmed word");
    lat = LAT_W'(2);
    for (int a = 0; a < NW; a += 5) begin
      p = 8'(a) ^ 8'h5C;
      op2(a, 8'h40, p);
      model[a] = model[a] & p;
    end
    wr(0, 8'hFF, 1'b1);
    for (int a = 0; a < NW; a += 5) rd_chk(a, model[a], "R5 program ands data");

    // erase block 1
    op2(19, 8'h20, 8'hD0);
    for (int a = 16; a < 32; a++) model[a] = 8'hFF;
    wr(0, 8'hFF, 1'b0);
    for (int a = 0; a < NW; a++) rd_chk(a, model[a], "R6 erase block");

    // locks
    op2(32, 8'h60, 8'h01);
    op2(5, 8'h60, 8'h01);
    op2(60, 8'h60, 8'h01);
    wr(0, 8'h90, 1'b0);
    for (int b = 0; b < NB; b++)
      rd_chk(b*16 + 2, (b == 1) ? 8'h00 : 8'h01, "R7 lock bits");
    op2(40, 8'h20, 8'hD0);
    rd_chk(0, 8'hA2, "R7 erase locked block status");
    wr(0, 8'h50, 1'b0);
    rd_chk(0, 8'h80, "R11 clear keeps status mode");
    op2(33, 8'h40, 8'h00);
    rd_chk(0, 8'h92, "R7 program locked block status");
    wr(0, 8'hFF, 1'b0);
    for (int a = 32; a < 48; a++) rd_chk(a, model[a], "R7 locked block unchanged");
    wr(0, 8'h50, 1'b0);
    op2(7, 8'h60, 8'hD0);
    rd_chk(0, 8'h80, "R7 unlock status");
    wr(0, 8'h90, 1'b0);
    for (int b = 0; b < NB; b++) rd_chk(b*16 + 2, 8'h00, "R7 unlock all");

    // program-enable low
    prog_en = 1'b0;
    op2(5, 8'h40, 8'h00);
    rd_chk(0, 8'h98, "R8 program blocked status");
    wr(0, 8'h50, 1'b0);
    op2(48, 8'h60, 8'h01);
    rd_chk(0, 8'h98, "R8 lock blocked status");
    wr(0, 8'h50, 1'b0);
    op2(16, 8'h20, 8'hD0);
    rd_chk(0, 8'hA8, "R8 erase blocked status");
    wr(0, 8'h50, 1'b0);
    wr(0, 8'h90, 1'b0);
    rd_chk(50, 8'h00, "R8 lock not set");
    wr(0, 8'hFF, 1'b0);
    rd_chk(5, model[5], "R8 word unchanged");
    rd_chk(16, model[16], "R8 block unchanged");
    prog_en = 1'b1;

    // bad confirm
    wr(0, 8'h20, 1'b0);
    wr(0, 8'h77, 1'b0);
    chk("R10 no operation started", {7'b0, ready}, 8'h01);
    rd_chk(0, 8'hB0, "R10 bad erase confirm");
    wr(0, 8'h50, 1'b0);
    wr(0, 8'h60, 1'b0);
    wr(0, 8'h55, 1'b1);
    rd_chk(0, 8'hB0, "R10 bad lock confirm");
    wr(0, 8'hFF, 1'b0);
    wr(0, 8'h70, 1'b0);
    rd_chk(0, 8'hB0, "R11 errors sticky");
    wr(0, 8'h50, 1'b0);
    rd_chk(0, 8'h80, "R11 errors cleared");

    // writes ignored while busy
    lat = LAT_W'(20);
    wr(9, 8'h40, 1'b0);
    wr(9, 8'h0F, 1'b0);
    model[9] = model[9] & 8'h0F;
    rd_chk(0, 8'h00, "R9 busy status read");
    wr(0, 8'hFF, 1'b0);
    wait_ready(n);
    rd_chk(0, 8'h80, "R9 write during busy ignored");
    wr(0, 8'hFF, 1'b0);
    rd_chk(9, model[9], "R9 program completed");

    // device reset
    op2(2, 8'h60, 8'h01);
    lmodel[0] = 1'b1;
    wr(0, 8'h60, 1'b0);
    wr(0, 8'hD0, 1'b0);
    @(negedge clk); dev_rst_n = 1'b0;
    @(negedge clk); dev_rst_n = 1'b1;
    chk("R12 abort clears busy", {7'b0, ready}, 8'h01);
    rd_chk(0, model[0], "R12 array mode after reset");
    wr(0, 8'h90, 1'b0);
    rd_chk(2, {7'b0, lmodel[0]}, "R12 lock kept after abort");
    wr(0, 8'hFF, 1'b0);
    wr(3, 8'h40, 1'b0);
    @(negedge clk); dev_rst_n = 1'b0;
    @(negedge clk); dev_rst_n = 1'b1;
    wr(3, 8'h00, 1'b1);
    chk("R12 pending dropped no busy", {7'b0, ready}, 8'h01);
    rd_chk(3, model[3], "R12 pending dropped");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule